// File: doc/BRIEF.md
# Serial Float-to-Integer Converter with Range Bypass

This block turns a single-precision floating-point operand into a 32-bit integer, either signed (two's complement) or unsigned. The fraction is truncated, so rounding is always toward zero. An accepted start pulse launches the conversion. For operands that fit, the mantissa, with its hidden bit restored, is shifted left one bit position per clock. The number of shift cycles equals the unbiased exponent. When the last shift is done, the magnitude is range-checked and negated if needed, and the result appears together with a one-cycle done pulse and an invalid flag.

A pre-check decodes the operand in the same cycle that start is accepted. Some operands never enter the shift loop:
- NaN.
- A negative nonzero value in unsigned mode.
- A magnitude below one.
- An unbiased exponent of 32 or more, which could never fit the destination.

For these the block returns a fixed default on the very next clock. Shift-loop latency is therefore capped by the destination width rather than by the exponent range. The slowest case is 33 cycles, well inside a 128-cycle watchdog that a surrounding pipeline may impose on multi-cycle operations.

Top module: `f2i_serial`

## Requirements
- R1: After reset, done_o is 0, result_o is 0 and invalid_o is 0.
- R2: For an unbiased exponent e with 0 <= e <= 31 (exponent field 127..158), and a value that fits, the result is the value truncated toward zero, with invalid_o = 0. Signed mode returns two's complement. Fractional bits are dropped for both signs.
- R3: An operand that takes the shift path (R2 range, not otherwise bypassed) raises done_o e+2 rising edges after start is sampled. The sampling edge is counted as edge 1.
- R4: A bypassed operand raises done_o on the first rising edge after start is sampled. Bypassed operands are NaN, unsigned negative nonzero, exponent field below 127, or exponent field 159 or above.
- R5: In signed mode, an overflowing value saturates and sets invalid_o = 1. Positive overflow gives 0x7FFFFFFF and negative overflow gives 0x80000000, and infinities are included. Exactly -2^31 gives 0x80000000 with invalid_o = 0.
- R6: In unsigned mode, any negative nonzero operand, including -infinity, gives 0 with invalid_o = 1. Magnitudes of 2^32 or more, including +infinity, give 0xFFFFFFFF with invalid_o = 1. Negative zero gives 0 with invalid_o = 0.
- R7: A NaN operand of either sign (exponent field 255, nonzero fraction) gives 0x7FFFFFFF in signed mode and 0xFFFFFFFF in unsigned mode, with invalid_o = 1.
- R8: A magnitude below one gives 0 with invalid_o = 0. This covers zero, subnormals and exponent field below 127, with either sign in signed mode and a positive sign in unsigned mode.
- R9: done_o is high for exactly one cycle per accepted start. A start pulse while a conversion is in progress is ignored: no extra done_o, and the pending result is unchanged.
- R10: For every exponent field value 0..255, done_o rises no more than 128 cycles after start.
- R11: result_o and invalid_o hold their values from one done_o pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| operand_i | input | 32 | Single-precision operand, sampled with start |
| signed_i | input | 1 | 1 = signed destination, 0 = unsigned |
| result_o | output | 32 | Converted integer, valid with done_o and held afterwards |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Invalid-operation flag, valid with done_o and held afterwards |

## Verification
The assertions assume three things:
- Reset is asserted before the first start.
- The operand and mode are meaningful only in the cycle that start is sampled while idle.
- The latched sign and mode describe the result being delivered.

Under these assumptions, the shift counter must fall by one per cycle, the busy period must end before the destination width is reached, and an accepted result's sign must agree with the operand. The stimulus changes inputs only on falling clock edges and normally starts a new conversion only after done_o. The one exception is a deliberate start issued mid-conversion, used to show that a busy block ignores it.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    // Top-level sequencing: idle (accepting start) or walking the shift loop.
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } f2i_state_e;
endpackage

// File: rtl/f2i_decode.sv
// Operand classification and range pre-check. Decides in the start cycle
// whether the serial loop is needed, and if not, what the result is.
module f2i_decode #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FLT_W = 1 + EXP_W + MAN_W,
    localparam int CNT_W = $clog2(INT_W)
) (
    input  logic [FLT_W-1:0] operand,
    input  logic             smode,
    output logic             sign,
    output logic             bypass,
    output logic [INT_W-1:0] byp_result,
    output logic             byp_invalid,
    output logic [CNT_W-1:0] shift_cnt,
    output logic [MAN_W:0]   mant_ext
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] OVF_V  = EXP_W'(BIAS + INT_W);
    localparam logic [INT_W-1:0] MAX_S  = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_S  = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] MAX_U  = {INT_W{1'b1}};

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             is_nan;
    logic             nonzero;

    always_comb begin
        exp_f       = operand[FLT_W-2:MAN_W];
        man_f       = operand[MAN_W-1:0];
        sign        = operand[FLT_W-1];
        is_nan      = (exp_f == {EXP_W{1'b1}}) && (man_f != '0);
        nonzero     = |operand[FLT_W-2:0];
        mant_ext    = {1'b1, man_f};
        shift_cnt   = CNT_W'(exp_f - BIAS_V);
        bypass      = 1'b1;
        byp_invalid = 1'b0;
        byp_result  = '0;
        if (is_nan) begin
            byp_invalid = 1'b1;
            byp_result  = smode ? MAX_S : MAX_U;
        end else if (!smode && sign && nonzero) begin
            byp_invalid = 1'b1;
        end else if (exp_f < BIAS_V) begin
            byp_result  = '0;
        end else if (exp_f >= OVF_V) begin
            byp_invalid = 1'b1;
            byp_result  = smode ? (sign ? MIN_S : MAX_S) : MAX_U;
        end else begin
            bypass      = 1'b0;
        end
    end
endmodule

// File: rtl/f2i_shifter.sv
// Serial normalizer: one left shift per clock, count loaded from exponent.
module f2i_shifter #(
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int CNT_W = $clog2(INT_W),
    localparam int ACC_W = INT_W + MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [MAN_W:0]   load_mant,
    output logic             last,
    output logic [INT_W-1:0] magnitude
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.active = 1'b1;
            d.cnt    = load_cnt;
            d.acc    = {{(ACC_W-MAN_W-1){1'b0}}, load_mant};
        end else if (q.active) begin
            if (q.cnt == '0) begin
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
                d.acc = {q.acc[ACC_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign last      = q.active && (q.cnt == '0);
    assign magnitude = q.acc[ACC_W-1:MAN_W];

    // R3: the loop advances exactly one position per clock
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cnt != '0 && !load) |=> (q.active && q.cnt == $past(q.cnt) - 1'b1));

    // R3: a load starts the loop with the decoded distance
    a_r3_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.active && q.cnt == $past(load_cnt)));
endmodule

// File: rtl/f2i_pack.sv
// Final range check and sign application on the shifted magnitude.
module f2i_pack #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] magnitude,
    input  logic             sign,
    input  logic             smode,
    output logic [INT_W-1:0] result,
    output logic             invalid
);
    localparam logic [INT_W-1:0] MAX_S = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_S = {1'b1, {(INT_W-1){1'b0}}};

    always_comb begin
        result  = magnitude;
        invalid = 1'b0;
        if (smode) begin
            if (sign) begin
                if (magnitude > MIN_S) begin
                    result  = MIN_S;
                    invalid = 1'b1;
                end else begin
                    result  = (~magnitude) + 1'b1;
                end
            end else if (magnitude[INT_W-1]) begin
                result  = MAX_S;
                invalid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/f2i_serial.sv
module f2i_serial #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FLT_W = 1 + EXP_W + MAN_W,
    localparam int CNT_W = $clog2(INT_W),
    localparam int LAT_W = $clog2(INT_W) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [FLT_W-1:0] operand_i,
    input  logic             signed_i,
    output logic [INT_W-1:0] result_o,
    output logic             done_o,
    output logic             invalid_o
);
    import f2i_pkg::*;

    typedef struct packed {
        f2i_state_e       state;
        logic             sign;
        logic             smode;
        logic [INT_W-1:0] result;
        logic             invalid;
        logic             done;
    } top_t;

    top_t q, d;

    logic             dec_sign, dec_bypass, dec_inv;
    logic [INT_W-1:0] dec_res;
    logic [CNT_W-1:0] dec_cnt;
    logic [MAN_W:0]   dec_mant;
    logic             sh_load, sh_last;
    logic [INT_W-1:0] sh_mag, pk_res;
    logic             pk_inv;

    f2i_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_decode (
        .operand     (operand_i),
        .smode       (signed_i),
        .sign        (dec_sign),
        .bypass      (dec_bypass),
        .byp_result  (dec_res),
        .byp_invalid (dec_inv),
        .shift_cnt   (dec_cnt),
        .mant_ext    (dec_mant)
    );

    assign sh_load = (q.state == ST_IDLE) && start_i && !dec_bypass;

    f2i_shifter #(.MAN_W(MAN_W), .INT_W(INT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_cnt  (dec_cnt),
        .load_mant (dec_mant),
        .last      (sh_last),
        .magnitude (sh_mag)
    );

    f2i_pack #(.INT_W(INT_W)) u_pack (
        .magnitude (sh_mag),
        .sign      (q.sign),
        .smode     (q.smode),
        .result    (pk_res),
        .invalid   (pk_inv)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.sign  = dec_sign;
                    d.smode = signed_i;
                    if (dec_bypass) begin
                        d.result  = dec_res;
                        d.invalid = dec_inv;
                        d.done    = 1'b1;
                    end else begin
                        d.state = ST_SHIFT;
                    end
                end
            end
            ST_SHIFT: begin
                if (sh_last) begin
                    d.result  = pk_res;
                    d.invalid = pk_inv;
                    d.done    = 1'b1;
                    d.state   = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result_o  = q.result;
    assign done_o    = q.done;
    assign invalid_o = q.invalid;

    // Busy-time counter observed only by the latency assertion.
    logic [LAT_W-1:0] lat_d, lat_q;
    always_comb lat_d = (q.state == ST_SHIFT) ? lat_q + 1'b1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    // R10: the shift loop never runs up to the destination width
    a_r10_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> (lat_q < LAT_W'(INT_W)));

    // R9: no completion pulse while a conversion is still in the loop
    a_r9_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> !done_o);

    // R2: a valid nonzero signed result carries the operand sign
    a_r2_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.smode && !invalid_o && result_o != '0) |-> (result_o[INT_W-1] == q.sign));

    // R6: an unsigned invalid result is one of the two extremes
    a_r6_unsigned_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !q.smode && invalid_o) |-> (result_o == '0 || result_o == '1));

    // R11: outputs only change on a completion
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(invalid_o)));
endmodule

// File: tb/f2i_serial_test.sv
`timescale 1ns/1ps
module f2i_serial_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] operand_i;
    logic        signed_i;
    logic [31:0] result_o;
    logic        done_o;
    logic        invalid_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    f2i_serial uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .signed_i(signed_i), .result_o(result_o), .done_o(done_o), .invalid_o(invalid_o)
    );

    // {operand, signed, result, invalid, latency, requirement}
    localparam int NV = 26;
    localparam logic [77:0] VEC [NV] = '{
        {32'h3F800000, 1'b1, 32'h00000001, 1'b0, 8'd2,  4'd2},
        {32'h40490FDB, 1'b1, 32'h00000003, 1'b0, 8'd3,  4'd2},
        {32'hC0490FDB, 1'b1, 32'hFFFFFFFD, 1'b0, 8'd3,  4'd2},
        {32'h3FFFFFFF, 1'b1, 32'h00000001, 1'b0, 8'd2,  4'd2},
        {32'hBFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b0, 8'd2,  4'd2},
        {32'h4B7FFFFF, 1'b0, 32'h00FFFFFF, 1'b0, 8'd25, 4'd2},
        {32'h4EFFFFFF, 1'b1, 32'h7FFFFF80, 1'b0, 8'd32, 4'd2},
        {32'h4F7FFFFF, 1'b0, 32'hFFFFFF00, 1'b0, 8'd33, 4'd2},
        {32'h4F000000, 1'b1, 32'h7FFFFFFF, 1'b1, 8'd33, 4'd5},
        {32'h4F000000, 1'b0, 32'h80000000, 1'b0, 8'd33, 4'd2},
        {32'hCF000000, 1'b1, 32'h80000000, 1'b0, 8'd33, 4'd5},
        {32'hCF000001, 1'b1, 32'h80000000, 1'b1, 8'd33, 4'd5},
        {32'h4F800000, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd1,  4'd6},
        {32'h4F800000, 1'b1, 32'h7FFFFFFF, 1'b1, 8'd1,  4'd5},
        {32'h7F000000, 1'b1, 32'h7FFFFFFF, 1'b1, 8'd1,  4'd10},
        {32'hFF000000, 1'b1, 32'h80000000, 1'b1, 8'd1,  4'd5},
        {32'h7FC00000, 1'b1, 32'h7FFFFFFF, 1'b1, 8'd1,  4'd7},
        {32'hFFC00000, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd1,  4'd7},
        {32'h7F800000, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd1,  4'd6},
        {32'hFF800000, 1'b1, 32'h80000000, 1'b1, 8'd1,  4'd5},
        {32'hFF800000, 1'b0, 32'h00000000, 1'b1, 8'd1,  4'd6},
        {32'hBF800000, 1'b0, 32'h00000000, 1'b1, 8'd1,  4'd6},
        {32'h80000000, 1'b0, 32'h00000000, 1'b0, 8'd1,  4'd6},
        {32'h3F000000, 1'b1, 32'h00000000, 1'b0, 8'd1,  4'd8},
        {32'h00000001, 1'b1, 32'h00000000, 1'b0, 8'd1,  4'd8},
        {32'hBF000000, 1'b1, 32'h00000000, 1'b0, 8'd1,  4'd8}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // Reference from the requirement text: {invalid, result}
    function automatic logic [32:0] model(input logic [31:0] a, input bit sm);
        logic [7:0]  ex = a[30:23];
        logic [22:0] mn = a[22:0];
        logic [63:0] mag;
        if (ex == 8'hFF && mn != 0) return sm ? {1'b1, 32'h7FFFFFFF} : {1'b1, 32'hFFFFFFFF};
        if (!sm && a[31] && a[30:0] != 0) return {1'b1, 32'h0};
        if (ex < 8'd127) return {1'b0, 32'h0};
        if (ex >= 8'd159) return sm ? (a[31] ? {1'b1, 32'h80000000} : {1'b1, 32'h7FFFFFFF})
                                    : {1'b1, 32'hFFFFFFFF};
        mag = ({40'd0, 1'b1, mn} << (ex - 8'd127)) >> 23;
        if (sm && a[31]) return (mag > 64'h80000000) ? {1'b1, 32'h80000000} : {1'b0, 32'(-mag)};
        if (sm)          return (mag >= 64'h80000000) ? {1'b1, 32'h7FFFFFFF} : {1'b0, mag[31:0]};
        return {1'b0, mag[31:0]};
    endfunction

    function automatic int model_lat(input logic [31:0] a, input bit sm);
        logic [7:0] ex = a[30:23];
        if ((ex == 8'hFF && a[22:0] != 0) || (!sm && a[31] && a[30:0] != 0) ||
            ex < 8'd127 || ex >= 8'd159) return 1;
        return int'(ex) - 127 + 2;
    endfunction

    task automatic run(input logic [31:0] a, input bit sm, output int lat);
        @(negedge clk);
        start_i = 1'b1; operand_i = a; signed_i = sm;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [32:0] m;
        rst_n = 1'b0; start_i = 1'b0; operand_i = '0; signed_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset done",    {31'd0, done_o},    32'd0);
        chk("R1", "reset result",  result_o,           32'd0);
        chk("R1", "reset invalid", {31'd0, invalid_o}, 32'd0);

        // Vector table: R2 R5 R6 R7 R8 R10 values, R3 R4 latency
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][3:0]);
            run(VEC[i][77:46], VEC[i][45], lat);
            chk(tag, $sformatf("vec%0d result", i), result_o, VEC[i][44:13]);
            chk(tag, $sformatf("vec%0d invalid", i), {31'd0, invalid_o}, {31'd0, VEC[i][12]});
            chk((VEC[i][11:4] == 8'd1) ? "R4" : "R3", $sformatf("vec%0d latency", i),
                32'(lat), {24'd0, VEC[i][11:4]});
            @(negedge clk);
            chk("R9", $sformatf("vec%0d pulse width", i), {31'd0, done_o}, 32'd0);
        end

        // R9 and R11: start while busy is ignored, outputs hold
        @(negedge clk);
        start_i = 1'b1; operand_i = 32'h49800000; signed_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            if (lat == 5) begin start_i = 1'b1; operand_i = 32'h7FC00000; end
            else start_i = 1'b0;
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        chk("R9", "busy start latency", 32'(lat), 32'd22);
        chk("R9", "busy start result",  result_o, 32'h00100000);
        chk("R9", "busy start invalid", {31'd0, invalid_o}, 32'd0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9",  "no extra done", {31'd0, done_o}, 32'd0);
            chk("R11", "result held",   result_o, 32'h00100000);
        end

        // R10 sweep of all exponent fields, both modes and signs
        for (int e = 0; e < 256; e++) begin
            for (int sm = 0; sm < 2; sm++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] a;
                    a = {s[0], e[7:0], 23'h2AAAAA};
                    m = model(a, sm[0]);
                    run(a, sm[0], lat);
                    chk("R10", $sformatf("sweep %08h/%0d bound", a, sm), 32'(lat <= 128), 32'd1);
                    chk((model_lat(a, sm[0]) == 1) ? "R4" : "R3",
                        $sformatf("sweep %08h/%0d latency", a, sm), 32'(lat), 32'(model_lat(a, sm[0])));
                    chk("R2", $sformatf("sweep %08h/%0d result", a, sm), result_o, m[31:0]);
                    chk("R2", $sformatf("sweep %08h/%0d invalid", a, sm), {31'd0, invalid_o}, {31'd0, m[32]});
                end
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule